// File: doc/BRIEF.md
# Interrupt and Event Recognition Unit

This block gathers the asynchronous events aimed at a processor core, keeps the ones that need remembering, and hands exactly one of them to the core at each instruction boundary. Four sources are handled. A non-maskable interrupt and a system-management interrupt are caught on their rising edge. A maskable interrupt is a plain level that must still be present and enabled when the boundary arrives. A bus-check indication is sampled on each bus ready strobe and held once seen.

Several conditions hold back recognition without losing an event. A held bus-check waits while a locked sequence or a snoop writeback is in progress. A non-maskable interrupt that is pending while the core runs in system-management mode (SMM) waits until an interrupt-return event has been seen in that mode, or until SMM is left. A system-management interrupt waits while the debug probe-ready status is active. When more than one event is eligible at a boundary, a fixed priority picks one and the others stay pending.

Top module: `evt_recog_unit`

## Requirements
- R1: While `rstN` is low, `recogVec` and `pendFlags` read zero and the SMM interrupt-return gate is cleared. The edge detectors see a level of zero at reset, so an edge input that is already high after reset produces one edge.
- R2: A rising edge on `nmiIn` (high now, low in the previous cycle) sets `pendFlags[0]` at that clock edge. The flag stays set when `nmiIn` falls, and a level that is held high sets it only once.
- R3: `recogVec[0]` (maskable interrupt) pulses only when `intrIn` and `intEnable` are both high in the boundary cycle. Nothing is latched for it, so a request that drops before the boundary is lost.
- R4: `pendFlags[2]` (bus-check) is set when `busChkIn` and `rdyStrobe` are both high. `busChkIn` without `rdyStrobe` has no effect. Once set, the flag stays set after `busChkIn` drops.
- R5: A pending bus-check is not recognized in a boundary cycle where `lockActive` or `snoopWbActive` is high. It stays pending, and it is recognized at the first boundary after both are low.
- R6: While `inSmm` is high, a pending non-maskable interrupt is recognized only after `iretEvt` has been seen in SMM. `smmExitEvt` clears that gate. With `inSmm` low, a pending non-maskable interrupt is eligible at any boundary.
- R7: A rising edge on `smiIn` sets `pendFlags[1]`. The interrupt is not recognized while `probeRdy` is high, and it is recognized at the first boundary after `probeRdy` is low.
- R8: Recognition happens only at a clock edge where `instrBoundary` is high. `recogVec` is one-hot, with bit 3 for bus-check, bit 2 for system-management, bit 1 for non-maskable and bit 0 for maskable. It pulses for one cycle after the boundary. Priority runs from bus-check (highest) through system-management and non-maskable to maskable (lowest).
- R9: A recognized latched event has its pending flag cleared at the same edge that raises its `recogVec` bit. Unrecognized pending events keep their flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| nmiIn | input | 1 | Non-maskable interrupt request (edge) |
| intrIn | input | 1 | Maskable interrupt request (level) |
| smiIn | input | 1 | System-management interrupt request (edge) |
| busChkIn | input | 1 | Bus-check indication |
| rdyStrobe | input | 1 | Bus ready strobe that samples bus-check |
| lockActive | input | 1 | Locked bus sequence in progress |
| snoopWbActive | input | 1 | Inquire cycle or its writeback in progress |
| probeRdy | input | 1 | Debug probe-ready status |
| intEnable | input | 1 | Interrupt-enable flag |
| inSmm | input | 1 | Core is in system-management mode |
| iretEvt | input | 1 | Interrupt-return executed (pulse) |
| smmExitEvt | input | 1 | Return from SMM executed (pulse) |
| instrBoundary | input | 1 | Instruction boundary (pulse) |
| recogVec | output | 4 | One-hot recognized event, valid for one cycle |
| pendFlags | output | 3 | Pending latches: [2] bus-check, [1] system-management, [0] non-maskable |

## Verification
Directed cases drive one source at a time, with and without its blocking condition. This separates edge capture from level sampling, and it separates deferral from loss of an event. For example, a bus-check raised without a ready strobe must leave no trace, while one raised with a strobe must survive the release of a lock. A case with every source pending, followed by a run of boundaries, shows the priority order and shows that each recognition clears only its own flag. Long random runs then mix edges, strobes, locks, SMM entry and exit, and probe activity, so that deferral and priority interact in orders the directed cases do not reach.

// File: rtl/evt_pkg.sv
package evt_pkg;
  localparam int NUM_EVT   = 4;
  localparam int NUM_LATCH = 3;
  localparam int NUM_EDGE  = 2;

  // recognized-event vector bit positions, index order is priority order
  localparam int IDX_INTR = 0;
  localparam int IDX_NMI  = 1;
  localparam int IDX_SMI  = 2;
  localparam int IDX_BCHK = 3;

  // pending latch positions; edge-captured sources occupy the low bits
  localparam int LAT_NMI  = 0;
  localparam int LAT_SMI  = 1;
  localparam int LAT_BCHK = 2;

  typedef struct packed {
    logic [NUM_LATCH-1:0] clrPend;
    logic [NUM_EVT-1:0]   recogNext;
  } evt_strobe_t;
endpackage

// File: rtl/evt_dpath.sv
module evt_dpath
  import evt_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 nmiIn,
  input  logic                 smiIn,
  input  logic                 busChkIn,
  input  logic                 rdyStrobe,
  input  evt_strobe_t          strobe,
  output logic [NUM_LATCH-1:0] pendFlags,
  output logic [NUM_EVT-1:0]   recogVec
);
  logic [NUM_EDGE-1:0]  edgeIn;
  logic [NUM_EDGE-1:0]  edgePrev;
  logic [NUM_LATCH-1:0] setPend;
  logic [NUM_LATCH-1:0] pendNext;
  logic [NUM_LATCH-1:0] pendQ;
  logic [NUM_EVT-1:0]   recogQ;

  assign edgeIn = {smiIn, nmiIn};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) edgePrev <= '0;
    else       edgePrev <= edgeIn;
  end

  for (genvar g = 0; g < NUM_EDGE; g++) begin : gEdge
    assign setPend[g] = edgeIn[g] & ~edgePrev[g];
  end

  assign setPend[LAT_BCHK] = rdyStrobe & busChkIn;

  // a fresh capture wins over a clear in the same cycle
  for (genvar l = 0; l < NUM_LATCH; l++) begin : gLatch
    assign pendNext[l] = (pendQ[l] & ~strobe.clrPend[l]) | setPend[l];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendQ  <= '0;
      recogQ <= '0;
    end else begin
      pendQ  <= pendNext;
      recogQ <= strobe.recogNext;
    end
  end

  assign pendFlags = pendQ;
  assign recogVec  = recogQ;
endmodule

// File: rtl/evt_ctrl.sv
module evt_ctrl
  import evt_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_LATCH-1:0] pendFlags,
  input  logic                 intrIn,
  input  logic                 intEnable,
  input  logic                 lockActive,
  input  logic                 snoopWbActive,
  input  logic                 probeRdy,
  input  logic                 inSmm,
  input  logic                 iretEvt,
  input  logic                 smmExitEvt,
  input  logic                 instrBoundary,
  output evt_strobe_t          strobe
);
  logic               iretSeenQ;
  logic [NUM_EVT-1:0] elig;
  logic [NUM_EVT-1:0] grant;
  logic               taken;

  // gate that lets a non-maskable interrupt through while in SMM
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 iretSeenQ <= 1'b0;
    else if (smmExitEvt)       iretSeenQ <= 1'b0;
    else if (iretEvt && inSmm) iretSeenQ <= 1'b1;
  end

  assign elig[IDX_BCHK] = pendFlags[LAT_BCHK] & ~lockActive & ~snoopWbActive;
  assign elig[IDX_SMI]  = pendFlags[LAT_SMI] & ~probeRdy;
  assign elig[IDX_NMI]  = pendFlags[LAT_NMI] & (~inSmm | iretSeenQ);
  assign elig[IDX_INTR] = intrIn & intEnable;

  always_comb begin
    grant = '0;
    taken = 1'b0;
    for (int i = NUM_EVT - 1; i >= 0; i--) begin
      if (instrBoundary && elig[i] && !taken) begin
        grant[i] = 1'b1;
        taken    = 1'b1;
      end
    end
  end

  always_comb begin
    strobe                   = '0;
    strobe.recogNext         = grant;
    strobe.clrPend[LAT_NMI]  = grant[IDX_NMI];
    strobe.clrPend[LAT_SMI]  = grant[IDX_SMI];
    strobe.clrPend[LAT_BCHK] = grant[IDX_BCHK];
  end
endmodule

// File: rtl/evt_recog_unit.sv
module evt_recog_unit
  import evt_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 nmiIn,
  input  logic                 intrIn,
  input  logic                 smiIn,
  input  logic                 busChkIn,
  input  logic                 rdyStrobe,
  input  logic                 lockActive,
  input  logic                 snoopWbActive,
  input  logic                 probeRdy,
  input  logic                 intEnable,
  input  logic                 inSmm,
  input  logic                 iretEvt,
  input  logic                 smmExitEvt,
  input  logic                 instrBoundary,
  output logic [NUM_EVT-1:0]   recogVec,
  output logic [NUM_LATCH-1:0] pendFlags
);
  evt_strobe_t strobe;

  evt_ctrl u_ctrl (
    .clk           (clk),
    .rstN          (rstN),
    .pendFlags     (pendFlags),
    .intrIn        (intrIn),
    .intEnable     (intEnable),
    .lockActive    (lockActive),
    .snoopWbActive (snoopWbActive),
    .probeRdy      (probeRdy),
    .inSmm         (inSmm),
    .iretEvt       (iretEvt),
    .smmExitEvt    (smmExitEvt),
    .instrBoundary (instrBoundary),
    .strobe        (strobe)
  );

  evt_dpath u_dpath (
    .clk       (clk),
    .rstN      (rstN),
    .nmiIn     (nmiIn),
    .smiIn     (smiIn),
    .busChkIn  (busChkIn),
    .rdyStrobe (rdyStrobe),
    .strobe    (strobe),
    .pendFlags (pendFlags),
    .recogVec  (recogVec)
  );
endmodule

// File: rtl/evt_recog_chk.sv
module evt_recog_chk
  import evt_pkg::*;
(
  input logic                 clk,
  input logic                 rstN,
  input logic                 intrIn,
  input logic                 busChkIn,
  input logic                 rdyStrobe,
  input logic                 lockActive,
  input logic                 snoopWbActive,
  input logic                 probeRdy,
  input logic                 intEnable,
  input logic                 instrBoundary,
  input logic [NUM_EVT-1:0]   recogVec,
  input logic [NUM_LATCH-1:0] pendFlags
);
  assert_onehot_recog_R8: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(recogVec));

  assert_recog_at_boundary_R8: assert property (@(posedge clk) disable iff (!rstN)
    (|recogVec) |-> $past(instrBoundary));

  assert_bchk_deferred_R5: assert property (@(posedge clk) disable iff (!rstN)
    recogVec[IDX_BCHK] |-> $past(!lockActive && !snoopWbActive));

  assert_smi_probe_R7: assert property (@(posedge clk) disable iff (!rstN)
    recogVec[IDX_SMI] |-> !$past(probeRdy));

  assert_intr_level_R3: assert property (@(posedge clk) disable iff (!rstN)
    recogVec[IDX_INTR] |-> $past(intrIn && intEnable));

  assert_bchk_held_R4: assert property (@(posedge clk) disable iff (!rstN)
    recogVec[IDX_BCHK] |-> $past(pendFlags[LAT_BCHK]));

  assert_bchk_cleared_R9: assert property (@(posedge clk) disable iff (!rstN)
    recogVec[IDX_BCHK] |-> (!pendFlags[LAT_BCHK] || $past(rdyStrobe && busChkIn)));
endmodule

bind evt_recog_unit evt_recog_chk u_chk (
  .clk           (clk),
  .rstN          (rstN),
  .intrIn        (intrIn),
  .busChkIn      (busChkIn),
  .rdyStrobe     (rdyStrobe),
  .lockActive    (lockActive),
  .snoopWbActive (snoopWbActive),
  .probeRdy      (probeRdy),
  .intEnable     (intEnable),
  .instrBoundary (instrBoundary),
  .recogVec      (recogVec),
  .pendFlags     (pendFlags)
);

// File: tb/evt_recog_unit_tb.sv
module evt_recog_unit_tb;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rstN, nmiIn, intrIn, smiIn, busChkIn, rdyStrobe, lockActive, snoopWbActive;
  logic probeRdy, intEnable, inSmm, iretEvt, smmExitEvt, instrBoundary;
  logic [3:0] recogVec;
  logic [2:0] pendFlags;

  int checks = 0;
  int fails = 0;
  bit finished = 0;
  string curTag = "R1";

  // reference state
  logic mNmiPrev, mSmiPrev, mIret;
  logic [2:0] mPend;
  logic [3:0] mRecog;

  evt_recog_unit u_dut (
    .clk(clk), .rstN(rstN), .nmiIn(nmiIn), .intrIn(intrIn), .smiIn(smiIn),
    .busChkIn(busChkIn), .rdyStrobe(rdyStrobe), .lockActive(lockActive),
    .snoopWbActive(snoopWbActive), .probeRdy(probeRdy), .intEnable(intEnable),
    .inSmm(inSmm), .iretEvt(iretEvt), .smmExitEvt(smmExitEvt),
    .instrBoundary(instrBoundary), .recogVec(recogVec), .pendFlags(pendFlags)
  );

  function automatic logic [3:0] pickOne(input logic [3:0] e);
    if (e[3]) return 4'b1000;
    if (e[2]) return 4'b0100;
    if (e[1]) return 4'b0010;
    if (e[0]) return 4'b0001;
    return 4'b0000;
  endfunction

  task automatic checkVal(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step();
    logic [3:0] elig, g;
    logic [2:0] setP, nPend;
    logic nIret;
    elig[3] = mPend[2] & ~lockActive & ~snoopWbActive;
    elig[2] = mPend[1] & ~probeRdy;
    elig[1] = mPend[0] & (~inSmm | mIret);
    elig[0] = intrIn & intEnable;
    g = instrBoundary ? pickOne(elig) : 4'b0000;
    setP = {rdyStrobe & busChkIn, smiIn & ~mSmiPrev, nmiIn & ~mNmiPrev};
    nPend[0] = (mPend[0] & ~g[1]) | setP[0];
    nPend[1] = (mPend[1] & ~g[2]) | setP[1];
    nPend[2] = (mPend[2] & ~g[3]) | setP[2];
    nIret = smmExitEvt ? 1'b0 : ((iretEvt & inSmm) ? 1'b1 : mIret);
    @(posedge clk);
    #1;
    if (!rstN) begin
      mNmiPrev = 0; mSmiPrev = 0; mIret = 0; mPend = '0; mRecog = '0;
    end else begin
      mNmiPrev = nmiIn; mSmiPrev = smiIn; mIret = nIret; mPend = nPend; mRecog = g;
    end
    checkVal(curTag, {4'b0, recogVec}, {4'b0, mRecog});
    checkVal(curTag, {5'b0, pendFlags}, {5'b0, mPend});
  endtask

  task automatic steps(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic boundary();
    instrBoundary = 1; step(); instrBoundary = 0;
  endtask

  task automatic idleInputs();
    nmiIn = 0; intrIn = 0; smiIn = 0; busChkIn = 0; rdyStrobe = 0; lockActive = 0;
    snoopWbActive = 0; probeRdy = 0; intEnable = 0; inSmm = 0; iretEvt = 0;
    smmExitEvt = 0; instrBoundary = 0;
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    #2000000;
    checks++; fails++;
    $display("FAIL watchdog: actual hung expected done");
    finishRun();
  end

  initial begin
    int seedDummy;
    seedDummy = $urandom(32'h5eed1);
    idleInputs();
    rstN = 0;
    mNmiPrev = 0; mSmiPrev = 0; mIret = 0; mPend = '0; mRecog = '0;
    // R1: outputs cleared while reset is held, even with activity on the inputs
    curTag = "R1";
    nmiIn = 1; smiIn = 1; busChkIn = 1; rdyStrobe = 1; instrBoundary = 1;
    steps(3);
    checkVal("R1", {4'b0, recogVec}, 8'h00);
    checkVal("R1", {5'b0, pendFlags}, 8'h00);
    idleInputs();
    rstN = 1;
    steps(2);

    // R2: edge captured, held after fall, held level latches once
    curTag = "R2";
    nmiIn = 1; step();
    checkVal("R2", {7'b0, pendFlags[0]}, 8'h01);
    steps(2); nmiIn = 0; step();
    boundary();
    checkVal("R2", {4'b0, recogVec}, 8'h02);
    nmiIn = 1; steps(2); boundary(); steps(2);
    checkVal("R2", {7'b0, pendFlags[0]}, 8'h00);
    nmiIn = 0; step();

    // R3: level must be present and enabled at the boundary
    curTag = "R3";
    intrIn = 1; intEnable = 0; boundary();
    checkVal("R3", {4'b0, recogVec}, 8'h00);
    intEnable = 1; boundary();
    checkVal("R3", {4'b0, recogVec}, 8'h01);
    intrIn = 0; step(); boundary();
    checkVal("R3", {4'b0, recogVec}, 8'h00);
    intEnable = 0;

    // R4: bus-check only through the ready strobe, then held
    curTag = "R4";
    busChkIn = 1; steps(2);
    checkVal("R4", {7'b0, pendFlags[2]}, 8'h00);
    rdyStrobe = 1; step(); rdyStrobe = 0; busChkIn = 0; steps(3);
    checkVal("R4", {7'b0, pendFlags[2]}, 8'h01);

    // R5: deferred under lock and snoop writeback
    curTag = "R5";
    lockActive = 1; boundary();
    checkVal("R5", {4'b0, recogVec}, 8'h00);
    lockActive = 0; snoopWbActive = 1; boundary();
    checkVal("R5", {4'b0, recogVec}, 8'h00);
    snoopWbActive = 0; boundary();
    checkVal("R5", {4'b0, recogVec}, 8'h08);
    checkVal("R5", {7'b0, pendFlags[2]}, 8'h00);

    // R6: SMM holds back the non-maskable interrupt until an interrupt return
    curTag = "R6";
    inSmm = 1; nmiIn = 1; step(); nmiIn = 0; boundary();
    checkVal("R6", {4'b0, recogVec}, 8'h00);
    iretEvt = 1; step(); iretEvt = 0; boundary();
    checkVal("R6", {4'b0, recogVec}, 8'h02);
    smmExitEvt = 1; step(); smmExitEvt = 0;
    nmiIn = 1; step(); nmiIn = 0; boundary();
    checkVal("R6", {4'b0, recogVec}, 8'h00);
    inSmm = 0; boundary();
    checkVal("R6", {4'b0, recogVec}, 8'h02);

    // R7: system-management interrupt waits for probe-ready to drop
    curTag = "R7";
    probeRdy = 1; smiIn = 1; step(); smiIn = 0; boundary();
    checkVal("R7", {4'b0, recogVec}, 8'h00);
    checkVal("R7", {7'b0, pendFlags[1]}, 8'h01);
    probeRdy = 0; boundary();
    checkVal("R7", {4'b0, recogVec}, 8'h04);

    // R8 and R9: everything pending, drained in priority order
    curTag = "R8";
    nmiIn = 1; smiIn = 1; busChkIn = 1; rdyStrobe = 1; step();
    nmiIn = 0; smiIn = 0; busChkIn = 0; rdyStrobe = 0; intrIn = 1; intEnable = 1;
    checkVal("R9", {5'b0, pendFlags}, 8'h07);
    boundary(); checkVal("R8", {4'b0, recogVec}, 8'h08);
    checkVal("R9", {5'b0, pendFlags}, 8'h03);
    boundary(); checkVal("R8", {4'b0, recogVec}, 8'h04);
    checkVal("R9", {5'b0, pendFlags}, 8'h01);
    boundary(); checkVal("R8", {4'b0, recogVec}, 8'h02);
    boundary(); checkVal("R8", {4'b0, recogVec}, 8'h01);
    step(); checkVal("R8", {4'b0, recogVec}, 8'h00);
    idleInputs(); step();

    // random mix compared cycle by cycle with the reference
    curTag = "R8 random";
    for (int n = 0; n < 4000; n++) begin
      nmiIn         = ($urandom % 5) == 0;
      smiIn         = ($urandom % 7) == 0;
      intrIn        = ($urandom % 3) == 0;
      intEnable     = ($urandom % 2) == 0;
      busChkIn      = ($urandom % 4) == 0;
      rdyStrobe     = ($urandom % 2) == 0;
      if (($urandom % 8) == 0) lockActive = ~lockActive;
      if (($urandom % 10) == 0) snoopWbActive = ~snoopWbActive;
      if (($urandom % 12) == 0) probeRdy = ~probeRdy;
      if (($urandom % 40) == 0) inSmm = ~inSmm;
      iretEvt       = ($urandom % 15) == 0;
      smmExitEvt    = ($urandom % 30) == 0;
      instrBoundary = ($urandom % 3) == 0;
      if (($urandom % 500) == 0) rstN = 0; else rstN = 1;
      step();
    end
    idleInputs(); rstN = 1; step();
    finishRun();
  end
endmodule